// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address into a physical frame after a translation-cache miss. It takes one request at a time, carrying a 64-bit virtual address, a read/write flag and a user/kernel flag. It first sorts the address into a region by its two top bits. A region that maps straight to physical memory is answered at once. Any other region is resolved by reading three table entries from memory, one for each level.

Each level of the table fills one 8 KiB page of 1024 eight-byte entries. The root page is named by a base frame register. Every later page is named by the frame field of the valid entry read at the level above. The result is either a physical frame number with the leaf entry's permission bits, or a fault code together with the level at which the walk stopped.

Memory is reached through a read port that holds a request until it is accepted and then waits for a single response beat. The result is presented as a one-cycle pulse.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_rd_valid` and `rsp_valid` are 0.
- R2: Address bits [63:62] pick the region. The value 2'b10 is the direct kernel region. The values 2'b00, 2'b01 and 2'b11 go through the table.
- R3: A direct-region request in kernel mode reads no memory. In the cycle after acceptance it returns `rsp_pfn` = va[39:13], `rsp_perm` = 4'b0011, `rsp_fault` = 0 and `rsp_level` = 0.
- R4: The level-n entry address is {table_frame, 13'b0} + 8*index_n. The index for level 1 is va[42:33], for level 2 va[32:23] and for level 3 va[22:13]. The level-1 table frame is `ptbr_pfn`, and each later table frame is the frame field of the previous entry.
- R5: Each entry is laid out as bit 0 valid, bits [4:1] permissions and bits [58:32] frame number. The permission bits, from bit 1 upward, are kernel-read, kernel-write, user-read and user-write. A walk that succeeds makes exactly three reads and returns the leaf frame and its permission nibble with `rsp_fault` = 0 and `rsp_level` = 3.
- R6: The stack region (bits [63:62] = 2'b11) is translated exactly like the low user region.
- R7: The walk stops at the first entry whose valid bit is 0. It makes no further reads and reports `rsp_fault` = 1 with `rsp_level` set to that level (1 to 3), and with frame and permissions set to 0.
- R8: If the leaf permission selected by mode and access type is clear, the block reports `rsp_fault` = 2, `rsp_level` = 3, and frame and permissions set to 0.
- R9: A direct-region request in user mode reads no memory and reports `rsp_fault` = 2 with `rsp_level` = 0.
- R10: `req_ready` is 0 from the cycle after acceptance until the cycle after the one-cycle `rsp_valid` pulse, when it returns to 1.
- R11: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbr_pfn | input | 27 | Frame of the level-1 table page |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 40 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_pfn | output | 27 | Physical frame number (0 on fault) |
| rsp_perm | output | 4 | Leaf permissions (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 entry absent, 2 access denied |
| rsp_level | output | 2 | Level where the walk ended, 0 for the direct region |

## Verification
The hardest outcome to reach from the ports is a fault at level 2 or level 3. It needs a table whose earlier levels are valid and whose later entry is not. The bench's memory model holds a sparse entry map keyed by address. For each case it builds a full three-level chain and then clears the entry at exactly one level. It then checks that the read count equals the failing level. A second hard case is a request stalled on the memory side. The bench holds `mem_rd_ready` low for several cycles and also adds response latency, and it checks that the address stays fixed while the request waits.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [1:0] {
        SEG_USER_LOW   = 2'd0,
        SEG_USER_STACK = 2'd1,
        SEG_KDIRECT    = 2'd2
    } seg_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_DENIED = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    // permission nibble positions
    localparam int PERM_W  = 4;
    localparam int PERM_KR = 0;
    localparam int PERM_KW = 1;
    localparam int PERM_UR = 2;
    localparam int PERM_UW = 3;

    // entry layout
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_PERM_LSB  = 1;

endpackage

// File: rtl/pgwalk_seg_decode.sv
module pgwalk_seg_decode
    import pgwalk_pkg::*;
(
    input  logic [1:0] top_bits,
    output seg_e       seg
);
    always_comb begin
        case (top_bits)
            2'b10:   seg = SEG_KDIRECT;
            2'b11:   seg = SEG_USER_STACK;
            default: seg = SEG_USER_LOW;
        endcase
    end
endmodule

// File: rtl/pgwalk_perm_check.sv
module pgwalk_perm_check
    import pgwalk_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic              is_user,
    input  logic              is_write,
    output logic              allow
);
    always_comb begin
        case ({is_user, is_write})
            2'b00:   allow = perm[PERM_KR];
            2'b01:   allow = perm[PERM_KW];
            2'b10:   allow = perm[PERM_UR];
            default: allow = perm[PERM_UW];
        endcase
    end
endmodule

// File: rtl/pgwalk_index_sel.sv
module pgwalk_index_sel #(
    parameter int OFS_W  = 13,
    parameter int IDX_W  = 10,
    parameter int LEVELS = 3,
    localparam int TVA_W = OFS_W + LEVELS * IDX_W,
    localparam int LVL_W = $clog2(LEVELS + 1)
) (
    input  logic [TVA_W-1:0] va,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_by_lvl [LEVELS];

    // level 1 takes the topmost index field
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign idx_by_lvl[g] = va[OFS_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (lvl == LVL_W'(k + 1)) idx = idx_by_lvl[k];
        end
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VA_W        = 64,
    parameter int PA_W        = 40,
    parameter int OFS_W       = 13,
    parameter int IDX_W       = 10,
    parameter int LEVELS      = 3,
    parameter int PTE_W       = 64,
    parameter int PTE_PFN_LSB = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_va,
    input  logic                    req_write,
    input  logic                    req_user,
    input  logic [PA_W-OFS_W-1:0]   ptbr_pfn,
    output logic                    mem_rd_valid,
    input  logic                    mem_rd_ready,
    output logic [PA_W-1:0]         mem_rd_addr,
    input  logic                    mem_rsp_valid,
    input  logic [PTE_W-1:0]        mem_rsp_data,
    output logic                    rsp_valid,
    output logic [PA_W-OFS_W-1:0]   rsp_pfn,
    output logic [3:0]              rsp_perm,
    output logic [1:0]              rsp_fault,
    output logic [1:0]              rsp_level
);
    localparam int PFN_W = PA_W - OFS_W;
    localparam int TVA_W = OFS_W + LEVELS * IDX_W;
    localparam int LVL_W = $clog2(LEVELS + 1);
    localparam int ENT_SHIFT = 3;

    typedef struct packed {
        state_e              st;
        logic [LVL_W-1:0]    lvl;
        logic [PFN_W-1:0]    base;
        logic [TVA_W-1:0]    va;
        logic                user;
        logic                wr;
        logic [PFN_W-1:0]    pfn;
        logic [PERM_W-1:0]   perm;
        fault_e              fault;
    } walk_t;

    walk_t walk_q, walk_d;

    seg_e                 seg;
    logic [IDX_W-1:0]     cur_idx;
    logic                 pte_valid;
    logic [PERM_W-1:0]    pte_perm;
    logic [PFN_W-1:0]     pte_pfn;
    logic                 leaf_allow;

    pgwalk_seg_decode u_seg (
        .top_bits (req_va[VA_W-1 -: 2]),
        .seg      (seg)
    );

    pgwalk_index_sel #(
        .OFS_W  (OFS_W),
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS)
    ) u_idx (
        .va  (walk_q.va),
        .lvl (walk_q.lvl),
        .idx (cur_idx)
    );

    assign pte_valid = mem_rsp_data[PTE_VALID_BIT];
    assign pte_perm  = mem_rsp_data[PTE_PERM_LSB +: PERM_W];
    assign pte_pfn   = mem_rsp_data[PTE_PFN_LSB +: PFN_W];

    pgwalk_perm_check u_perm (
        .perm     (pte_perm),
        .is_user  (walk_q.user),
        .is_write (walk_q.wr),
        .allow    (leaf_allow)
    );

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va   = req_va[TVA_W-1:0];
                    walk_d.user = req_user;
                    walk_d.wr   = req_write;
                    walk_d.pfn  = '0;
                    walk_d.perm = '0;
                    walk_d.fault = FLT_NONE;
                    if (seg == SEG_KDIRECT) begin
                        walk_d.st  = ST_DONE;
                        walk_d.lvl = '0;
                        if (req_user) begin
                            walk_d.fault = FLT_DENIED;
                        end else begin
                            walk_d.pfn = req_va[PA_W-1:OFS_W];
                            walk_d.perm[PERM_KR] = 1'b1;
                            walk_d.perm[PERM_KW] = 1'b1;
                        end
                    end else begin
                        walk_d.st   = ST_ISSUE;
                        walk_d.lvl  = LVL_W'(1);
                        walk_d.base = ptbr_pfn;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_rd_ready) walk_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_valid) begin
                        walk_d.st    = ST_DONE;
                        walk_d.fault = FLT_ABSENT;
                    end else if (walk_q.lvl == LVL_W'(LEVELS)) begin
                        walk_d.st = ST_DONE;
                        if (leaf_allow) begin
                            walk_d.pfn  = pte_pfn;
                            walk_d.perm = pte_perm;
                        end else begin
                            walk_d.fault = FLT_DENIED;
                        end
                    end else begin
                        walk_d.st   = ST_ISSUE;
                        walk_d.base = pte_pfn;
                        walk_d.lvl  = walk_q.lvl + LVL_W'(1);
                    end
                end
            end
            default: begin
                walk_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready    = (walk_q.st == ST_IDLE);
    assign mem_rd_valid = (walk_q.st == ST_ISSUE);
    assign mem_rd_addr  = {walk_q.base, {OFS_W{1'b0}}}
                        + ({{(PA_W-IDX_W){1'b0}}, cur_idx} << ENT_SHIFT);
    assign rsp_valid    = (walk_q.st == ST_DONE);
    assign rsp_pfn      = walk_q.pfn;
    assign rsp_perm     = walk_q.perm;
    assign rsp_fault    = walk_q.fault;
    assign rsp_level    = 2'(walk_q.lvl);

    // R10: no second request taken while a walk is open
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: result is a single pulse followed by idle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R11: stalled read keeps its address
    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R4: entry reads are eight-byte aligned
    a_r4_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[ENT_SHIFT-1:0] == '0));

    // R7: absent fault always names a table level
    a_r7_absent_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_ABSENT) |-> (rsp_level != 2'd0));

    // R3 / R9: direct region never touches memory
    a_r9_direct_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && seg == SEG_KDIRECT) |=> (!mem_rd_valid && rsp_valid));

endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [26:0] PTBR = 27'h100;
    localparam logic [26:0] T2   = 27'h200;
    localparam logic [26:0] T3   = 27'h300;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_va;
    logic        req_write;
    logic        req_user;
    logic [26:0] ptbr_pfn;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [39:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic [26:0] rsp_pfn;
    logic [3:0]  rsp_perm;
    logic [1:0]  rsp_fault;
    logic [1:0]  rsp_level;

    int checks = 0;
    int failures = 0;
    int rd_count = 0;
    int mem_lat = 0;
    logic [39:0] rd_log [0:7];
    logic [63:0] pt_mem [logic [39:0]];

    logic [26:0] got_pfn;
    logic [3:0]  got_perm;
    logic [1:0]  got_fault;
    logic [1:0]  got_level;
    int          got_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwalk_top uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .ptbr_pfn(ptbr_pfn),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn),
        .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    function automatic logic [63:0] mk_pte(input logic v, input logic [3:0] perm,
                                           input logic [26:0] pfn);
        return {5'b0, pfn, 27'b0, perm, v};
    endfunction

    function automatic logic [39:0] ent_addr(input logic [26:0] tbl, input logic [9:0] idx);
        return {tbl, 13'b0} + {27'b0, idx, 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory responder: samples 2 time units after each falling edge
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        @(negedge clk);
        forever begin
            #2;
            if (mem_rd_valid && mem_rd_ready) begin
                logic [39:0] a;
                a = mem_rd_addr;
                if (rd_count < 8) rd_log[rd_count] = a;
                rd_count++;
                @(negedge clk);
                repeat (mem_lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pt_mem.exists(a) ? pt_mem[a] : 64'h0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic build_walk(input logic [63:0] va, input logic [3:0] perm,
                              input logic [26:0] leaf);
        pt_mem.delete();
        pt_mem[ent_addr(PTBR, va[42:33])] = mk_pte(1'b1, 4'b0000, T2);
        pt_mem[ent_addr(T2,   va[32:23])] = mk_pte(1'b1, 4'b0000, T3);
        pt_mem[ent_addr(T3,   va[22:13])] = mk_pte(1'b1, perm, leaf);
    endtask

    task automatic wait_result();
        got_lat = 0;
        while (!rsp_valid && got_lat < 200) begin
            @(negedge clk);
            got_lat++;
        end
        got_pfn = rsp_pfn; got_perm = rsp_perm;
        got_fault = rsp_fault; got_level = rsp_level;
        @(negedge clk);
        chk("R10 pulse ends", {63'b0, rsp_valid}, 64'd0);
        chk("R10 ready again", {63'b0, req_ready}, 64'd1);
    endtask

    task automatic run_req(input logic [63:0] va, input logic wr, input logic user);
        rd_count = 0;
        req_va = va; req_write = wr; req_user = user; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low after accept", {63'b0, req_ready}, 64'd0);
        wait_result();
    endtask

    task automatic expect_res(input string tag, input logic [1:0] f, input logic [1:0] l,
                              input logic [26:0] pfn, input logic [3:0] perm, input int reads);
        chk({tag, " fault"}, {62'b0, got_fault}, {62'b0, f});
        chk({tag, " level"}, {62'b0, got_level}, {62'b0, l});
        chk({tag, " pfn"},   {37'b0, got_pfn},   {37'b0, pfn});
        chk({tag, " perm"},  {60'b0, got_perm},  {60'b0, perm});
        chk({tag, " reads"}, 64'(rd_count), 64'(reads));
    endtask

    task automatic t_reset();
        chk("R1 ready", {63'b0, req_ready}, 64'd1);
        chk("R1 mem idle", {63'b0, mem_rd_valid}, 64'd0);
        chk("R1 rsp idle", {63'b0, rsp_valid}, 64'd0);
    endtask

    task automatic t_user_walk();
        logic [63:0] va;
        va = {21'b0, 10'd3, 10'd5, 10'd7, 13'h123};
        build_walk(va, 4'b0101, 27'h45678);
        run_req(va, 1'b0, 1'b1);
        expect_res("R5 user read", 2'd0, 2'd3, 27'h45678, 4'b0101, 3);
        chk("R4 L1 addr", {24'b0, rd_log[0]}, {24'b0, ent_addr(PTBR, 10'd3)});
        chk("R4 L2 addr", {24'b0, rd_log[1]}, {24'b0, ent_addr(T2, 10'd5)});
        chk("R4 L3 addr", {24'b0, rd_log[2]}, {24'b0, ent_addr(T3, 10'd7)});
        // R2: bits 63:62 = 01 still walks
        va = {2'b01, 19'h5, 10'd1023, 10'd0, 10'd512, 13'h0};
        build_walk(va, 4'b0001, 27'h7FFFFFF);
        run_req(va, 1'b0, 1'b0);
        expect_res("R2 seg 01 walked", 2'd0, 2'd3, 27'h7FFFFFF, 4'b0001, 3);
        chk("R4 L1 top index", {24'b0, rd_log[0]}, {24'b0, ent_addr(PTBR, 10'd1023)});
    endtask

    task automatic t_stack_walk();
        logic [63:0] va;
        va = {2'b11, 19'h7FFFF, 10'd1, 10'd2, 10'd3, 13'h1FFF};
        build_walk(va, 4'b1111, 27'h70001);
        run_req(va, 1'b1, 1'b1);
        expect_res("R6 stack write", 2'd0, 2'd3, 27'h70001, 4'b1111, 3);
        chk("R6 L3 addr", {24'b0, rd_log[2]}, {24'b0, ent_addr(T3, 10'd3)});
    endtask

    task automatic t_kdirect();
        logic [63:0] va;
        pt_mem.delete();
        va = {2'b10, 22'h3ABCD, 27'h1234567, 13'h0AA};
        run_req(va, 1'b1, 1'b0);
        expect_res("R3 direct kernel", 2'd0, 2'd0, 27'h1234567, 4'b0011, 0);
        chk("R3 one-cycle answer", 64'(got_lat), 64'd0);
    endtask

    task automatic t_kdirect_user();
        logic [63:0] va;
        va = {2'b10, 22'h0, 27'h0000042, 13'h0};
        run_req(va, 1'b0, 1'b1);
        expect_res("R9 direct from user", 2'd2, 2'd0, 27'h0, 4'b0000, 0);
    endtask

    task automatic t_absent();
        logic [63:0] va;
        va = {21'b0, 10'd9, 10'd10, 10'd11, 13'h0};
        for (int lv = 1; lv <= 3; lv++) begin
            build_walk(va, 4'b1111, 27'h111);
            if (lv == 1) pt_mem[ent_addr(PTBR, 10'd9)] = mk_pte(1'b0, 4'b1111, T2);
            if (lv == 2) pt_mem[ent_addr(T2, 10'd10)]  = mk_pte(1'b0, 4'b1111, T3);
            if (lv == 3) pt_mem[ent_addr(T3, 10'd11)]  = mk_pte(1'b0, 4'b1111, 27'h111);
            run_req(va, 1'b0, 1'b0);
            expect_res($sformatf("R7 absent at L%0d", lv), 2'd1, 2'(lv), 27'h0, 4'b0000, lv);
        end
    endtask

    task automatic t_denied();
        logic [63:0] va;
        va = {21'b0, 10'd4, 10'd4, 10'd4, 13'h0};
        build_walk(va, 4'b0011, 27'h222);
        run_req(va, 1'b0, 1'b1);
        expect_res("R8 user read kernel-only", 2'd2, 2'd3, 27'h0, 4'b0000, 3);
        build_walk(va, 4'b0101, 27'h222);
        run_req(va, 1'b1, 1'b0);
        expect_res("R8 kernel write no kw", 2'd2, 2'd3, 27'h0, 4'b0000, 3);
        run_req(va, 1'b0, 1'b0);
        expect_res("R8 kernel read kr set", 2'd0, 2'd3, 27'h222, 4'b0101, 3);
        build_walk(va, 4'b1000, 27'h333);
        run_req(va, 1'b1, 1'b1);
        expect_res("R8 user write uw only", 2'd0, 2'd3, 27'h333, 4'b1000, 3);
        run_req(va, 1'b0, 1'b1);
        expect_res("R8 user read uw only", 2'd2, 2'd3, 27'h0, 4'b0000, 3);
    endtask

    task automatic t_stall();
        logic [63:0] va;
        va = {21'b0, 10'd6, 10'd8, 10'd2, 13'h0};
        build_walk(va, 4'b0100, 27'h5A5A);
        rd_count = 0;
        mem_rd_ready = 1'b0;
        mem_lat = 2;
        req_va = va; req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R11 request held", {63'b0, mem_rd_valid}, 64'd1);
            chk("R11 address held", {24'b0, mem_rd_addr}, {24'b0, ent_addr(PTBR, 10'd6)});
            @(negedge clk);
        end
        mem_rd_ready = 1'b1;
        wait_result();
        expect_res("R11 stalled walk", 2'd0, 2'd3, 27'h5A5A, 4'b0100, 3);
        mem_lat = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0;
        ptbr_pfn = PTBR;
        mem_rd_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_user_walk();
        t_stack_walk();
        t_kdirect();
        t_kdirect_user();
        t_absent();
        t_denied();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule